// File: doc/BRIEF.md
# DMA Peripheral Request Front End

This block sits between one peripheral and the program thread of a DMA channel. The peripheral raises single-transfer or burst-transfer requests. Each request goes into a small queue that remembers the request type. The channel thread issues commands on a valid/ready port:

- Two kinds of wait command stall the thread until a suitable request is queued. The kind of wait and the type of the oldest queued entry together decide whether that entry is consumed.
- A flush command empties the queue. It then ignores the peripheral until the peripheral confirms the flush with a handshake, which lets both sides start again from a known point.

The block also produces the transfer acknowledge to the peripheral. It watches the AXI read-data and write-response handshakes while a load-with-acknowledge or store-with-acknowledge is active. It raises sticky flags for a request that falls on a full queue. It raises another sticky flag for a peripheral that breaks the rule against sending a single request while a burst is still unacknowledged.

Top module: `dma_req_frontend`

## Requirements
- R1: A request is a one-cycle `reqValid` pulse, with `reqIsBurst` = 1 for a burst and 0 for a single. Accepted requests are queued in arrival order, and each entry keeps its type.
- R2: A wait-any command (`cmdKind` = 2'b00) stalls the thread while the queue is empty. While any wait is outstanding, `cmdReady` is low and `threadRelease` stays low.
- R3: Under wait-any, a single at the head of the queue is removed and the thread is released.
- R4: Under wait-any, a burst at the head of the queue is left in place and the thread is still released.
- R5: A wait-burst command (`cmdKind` = 2'b01) discards singles found at the head. It stalls until a burst reaches the head, then removes that burst and releases the thread.
- R6: A flush command (`cmdKind` = 2'b10) empties the queue in one cycle. Every request is ignored from that cycle until the cycle in which `flushAck` is seen high. Code 2'b11 is accepted and does nothing.
- R7: `periphAck` is high in exactly those cycles where `ackLoadEn`, `rValid` and `rLast` are all high, or where R8 applies.
- R8: `periphAck` is also high in any cycle where `ackStoreEn` and `bValid` are both high.
- R9: `protoError` rises, and then stays high, after a single request arrives while an earlier accepted burst has not yet been followed by a `periphAck` pulse. It does not rise if that acknowledge came in between.
- R10: A request that arrives while the queue holds `DEPTH` entries (default 4) is dropped, and `overflow` is set and stays set.
- R11: `threadRelease` is high for exactly one cycle. That cycle is the one after the wait's completing head check, and `cmdReady` is high again in the same cycle.
- R12: A synchronous active-high `rst` empties the queue, clears any pending flush and the sticky flags, and holds `threadRelease` and `periphAck` low. After reset, `cmdReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Peripheral request strobe |
| reqIsBurst | input | 1 | Request type: 1 burst, 0 single |
| flushAck | input | 1 | Peripheral confirms a flush |
| cmdValid | input | 1 | Thread command valid |
| cmdKind | input | 2 | 00 wait-any, 01 wait-burst, 10 flush, 11 no-op |
| cmdReady | output | 1 | Command port can accept |
| threadRelease | output | 1 | One-cycle pulse when a wait completes |
| ackLoadEn | input | 1 | Load-with-acknowledge in progress |
| ackStoreEn | input | 1 | Store-with-acknowledge in progress |
| rValid | input | 1 | Observed AXI read-data valid |
| rLast | input | 1 | Observed AXI read-data last |
| bValid | input | 1 | Observed AXI write-response valid |
| periphAck | output | 1 | Transfer acknowledge to the peripheral |
| overflow | output | 1 | Sticky: a request was dropped on a full queue |
| protoError | output | 1 | Sticky: single request during an unacknowledged burst |

## Verification
The hardest state to reach from the ports is a burst sitting at the head of the queue while wait commands keep arriving. Under wait-any, that entry must survive any number of releases, and only a later wait-burst may take it. The bench queues a burst ahead of a single and issues repeated wait-any commands. It then proves from the ports that the burst is still there: a wait-burst returns at once, and a final wait-any stalls only after both entries are gone. The flush window is reached the same way. Requests and a wait are driven while the flush is pending, and the check is that nothing releases until a request arrives after `flushAck`.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  typedef enum logic [1:0] {
    CMD_WAIT_ANY   = 2'b00,
    CMD_WAIT_BURST = 2'b01,
    CMD_FLUSH      = 2'b10,
    CMD_NOP        = 2'b11
  } cmdKind_e;

  // strobes from the control unit to the request queue
  typedef struct packed {
    logic push;
    logic pushIsBurst;
    logic pop;
    logic clear;
  } dpStrobe_t;

endpackage

// File: rtl/dma_req_fifo.sv
module dma_req_fifo
  import dma_req_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  dpStrobe_t strobe,
  output logic      empty,
  output logic      full,
  output logic      headIsBurst
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [DEPTH-1:0] slotBurst;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
  endfunction

  // one storage bit per slot: the entry type
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strobe.push && wrPtr == PTR_W'(g)) slotBurst[g] <= strobe.pushIsBurst;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= stepPtr(wrPtr);
      if (strobe.pop)  rdPtr <= stepPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign empty       = (count == '0);
  assign full        = (count == FULL_CNT);
  assign headIsBurst = slotBurst[rdPtr];

  assert_no_push_full_R10: assert property (@(posedge clk) disable iff (rst)
    strobe.push |-> !full);
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.pop |-> !empty);
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.clear |=> empty);
  assert_reset_empties_R12: assert property (@(posedge clk)
    rst |=> empty);

endmodule

// File: rtl/dma_req_control.sv
module dma_req_control
  import dma_req_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqIsBurst,
  input  logic       flushAck,
  input  logic       cmdValid,
  input  logic [1:0] cmdKind,
  output logic       cmdReady,
  output logic       threadRelease,
  input  logic       ackLoadEn,
  input  logic       ackStoreEn,
  input  logic       rValid,
  input  logic       rLast,
  input  logic       bValid,
  output logic       periphAck,
  output logic       overflow,
  output logic       protoError,
  input  logic       empty,
  input  logic       full,
  input  logic       headIsBurst,
  output dpStrobe_t  strobe
);

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e   state;
  cmdKind_e kind;
  logic     waitBurst;
  logic     flushPending;
  logic     burstOpen;
  logic     cmdFire, flushFire, reqSeen, waitDone;

  assign kind      = cmdKind_e'(cmdKind);
  assign cmdReady  = (state == ST_IDLE);
  assign cmdFire   = cmdValid && cmdReady;
  assign flushFire = cmdFire && (kind == CMD_FLUSH);
  // requests are blind from the flush cycle until the acknowledge is seen
  assign reqSeen   = reqValid && !flushPending && !flushFire;

  assign periphAck = !rst && ((ackLoadEn && rValid && rLast) ||
                              (ackStoreEn && bValid));

  always_comb begin
    strobe             = '0;
    strobe.push        = reqSeen && !full;
    strobe.pushIsBurst = reqIsBurst;
    strobe.clear       = flushFire;
    waitDone           = 1'b0;
    if (state == ST_WAIT && !empty) begin
      if (waitBurst) begin
        strobe.pop = 1'b1;
        waitDone   = headIsBurst;
      end else begin
        strobe.pop = !headIsBurst;
        waitDone   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      waitBurst     <= 1'b0;
      flushPending  <= 1'b0;
      burstOpen     <= 1'b0;
      overflow      <= 1'b0;
      protoError    <= 1'b0;
      threadRelease <= 1'b0;
    end else begin
      threadRelease <= waitDone;
      case (state)
        ST_IDLE: if (cmdFire && (kind == CMD_WAIT_ANY || kind == CMD_WAIT_BURST)) begin
          state     <= ST_WAIT;
          waitBurst <= (kind == CMD_WAIT_BURST);
        end
        default: if (waitDone) state <= ST_IDLE;
      endcase
      if (flushFire)                      flushPending <= 1'b1;
      else if (flushPending && flushAck)  flushPending <= 1'b0;
      if (reqSeen && full)                overflow <= 1'b1;
      if (reqSeen && !reqIsBurst && burstOpen) protoError <= 1'b1;
      if (flushFire)                      burstOpen <= 1'b0;
      else if (reqSeen && reqIsBurst)     burstOpen <= 1'b1;
      else if (periphAck)                 burstOpen <= 1'b0;
    end
  end

  assert_release_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    threadRelease |=> !threadRelease);
  assert_release_ready_R11: assert property (@(posedge clk) disable iff (rst)
    threadRelease |-> cmdReady);
  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (rst)
    (cmdFire && (kind == CMD_WAIT_ANY || kind == CMD_WAIT_BURST)) |=> !cmdReady);
  assert_proto_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    protoError |=> protoError);
  assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

endmodule

// File: rtl/dma_req_frontend.sv
module dma_req_frontend
  import dma_req_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqIsBurst,
  input  logic       flushAck,
  input  logic       cmdValid,
  input  logic [1:0] cmdKind,
  output logic       cmdReady,
  output logic       threadRelease,
  input  logic       ackLoadEn,
  input  logic       ackStoreEn,
  input  logic       rValid,
  input  logic       rLast,
  input  logic       bValid,
  output logic       periphAck,
  output logic       overflow,
  output logic       protoError
);

  dpStrobe_t strobe;
  logic      empty, full, headIsBurst;

  dma_req_control u_control (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqIsBurst(reqIsBurst), .flushAck(flushAck),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdReady(cmdReady),
    .threadRelease(threadRelease),
    .ackLoadEn(ackLoadEn), .ackStoreEn(ackStoreEn),
    .rValid(rValid), .rLast(rLast), .bValid(bValid),
    .periphAck(periphAck), .overflow(overflow), .protoError(protoError),
    .empty(empty), .full(full), .headIsBurst(headIsBurst),
    .strobe(strobe)
  );

  dma_req_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .strobe(strobe),
    .empty(empty), .full(full), .headIsBurst(headIsBurst)
  );

endmodule

// File: tb/dma_req_frontend_bench.sv
`timescale 1ns/1ps
module dma_req_frontend_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 0, reqIsBurst = 0, flushAck = 0, cmdValid = 0;
  logic [1:0] cmdKind = 2'b00;
  logic ackLoadEn = 0, ackStoreEn = 0, rValid = 0, rLast = 0, bValid = 0;
  logic cmdReady, threadRelease, periphAck, overflow, protoError;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dma_req_frontend u_dma_req_frontend (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqIsBurst(reqIsBurst),
    .flushAck(flushAck), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdReady(cmdReady), .threadRelease(threadRelease),
    .ackLoadEn(ackLoadEn), .ackStoreEn(ackStoreEn), .rValid(rValid),
    .rLast(rLast), .bValid(bValid), .periphAck(periphAck),
    .overflow(overflow), .protoError(protoError)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic doReset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic pushReq(input logic burst);
    reqValid = 1'b1; reqIsBurst = burst;
    step();
    reqValid = 1'b0; reqIsBurst = 1'b0;
  endtask

  task automatic issueCmd(input logic [1:0] k);
    cmdValid = 1'b1; cmdKind = k;
    step();
    cmdValid = 1'b0;
  endtask

  // expect a release within maxCyc cycles, then check it is one cycle wide
  task automatic expectRelease(input string req, input int maxCyc);
    logic got = 1'b0;
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      if (threadRelease) begin got = 1'b1; break; end
    end
    check(req, got, 1);
    @(negedge clk);
    check("R11", threadRelease, 0);
    check("R11", cmdReady, 1);
    step();
  endtask

  // expect the thread to stay stalled for n cycles
  task automatic expectStall(input string req, input int n);
    int rel = 0, rdy = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (threadRelease) rel++;
      if (cmdReady) rdy++;
    end
    check(req, rel, 0);
    check("R2", rdy, 0);
    step();
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    check("R12", cmdReady, 1);
    check("R12", threadRelease, 0);
    check("R12", periphAck, 0);
    check("R12", overflow, 0);
    check("R12", protoError, 0);
    step();
  endtask

  task automatic testWaitAnySingle();
    doReset();
    issueCmd(2'b00);
    expectStall("R2", 5);
    pushReq(1'b0);
    expectRelease("R2", 4);
    pushReq(1'b0);
    issueCmd(2'b00);
    expectRelease("R3", 4);
    issueCmd(2'b00);
    expectStall("R3", 5);   // the single was removed
    pushReq(1'b0);
    expectRelease("R3", 4);
  endtask

  task automatic testWaitAnyBurst();
    doReset();
    pushReq(1'b1);
    issueCmd(2'b00);
    expectRelease("R4", 4);
    issueCmd(2'b00);
    expectRelease("R4", 4);   // burst still at head
    issueCmd(2'b01);
    expectRelease("R4", 4);   // burst was still present
    issueCmd(2'b00);
    expectStall("R4", 5);
  endtask

  task automatic testOrder();
    doReset();
    pushReq(1'b1);
    pushReq(1'b0);
    issueCmd(2'b00);
    expectRelease("R1", 4);
    issueCmd(2'b01);
    expectRelease("R1", 4);
    issueCmd(2'b00);
    expectRelease("R1", 4);
    issueCmd(2'b00);
    expectStall("R1", 5);
  endtask

  task automatic testWaitBurst();
    doReset();
    pushReq(1'b0);
    pushReq(1'b0);
    pushReq(1'b1);
    issueCmd(2'b01);
    expectRelease("R5", 6);
    issueCmd(2'b00);
    expectStall("R5", 5);     // singles and burst all gone
    doReset();
    pushReq(1'b0);
    issueCmd(2'b01);
    expectStall("R5", 5);
    pushReq(1'b1);
    expectRelease("R5", 4);
    issueCmd(2'b00);
    expectStall("R5", 5);
  endtask

  task automatic testFlush();
    doReset();
    pushReq(1'b0);
    pushReq(1'b1);
    issueCmd(2'b10);
    pushReq(1'b0);
    pushReq(1'b1);
    issueCmd(2'b00);
    expectStall("R6", 6);
    flushAck = 1'b1;
    step();
    flushAck = 1'b0;
    expectStall("R6", 3);
    pushReq(1'b0);
    expectRelease("R6", 4);
    issueCmd(2'b11);
    @(negedge clk);
    check("R6", cmdReady, 1);
    step();
  endtask

  task automatic testOverflow();
    doReset();
    for (int i = 0; i < 4; i++) pushReq(1'b0);
    @(negedge clk);
    check("R10", overflow, 0);
    step();
    pushReq(1'b0);
    @(negedge clk);
    check("R10", overflow, 1);
    step();
    for (int i = 0; i < 4; i++) begin
      issueCmd(2'b00);
      expectRelease("R10", 4);
    end
    issueCmd(2'b00);
    expectStall("R10", 5);    // fifth request was dropped
    @(negedge clk);
    check("R10", overflow, 1);
    step();
  endtask

  task automatic testAck();
    doReset();
    ackLoadEn = 1; rValid = 1; rLast = 1;
    @(negedge clk); check("R7", periphAck, 1); step();
    rLast = 0;
    @(negedge clk); check("R7", periphAck, 0); step();
    ackLoadEn = 0; rLast = 1;
    @(negedge clk); check("R7", periphAck, 0); step();
    rValid = 0; rLast = 0;
    ackStoreEn = 1; bValid = 1;
    @(negedge clk); check("R8", periphAck, 1); step();
    ackStoreEn = 0;
    @(negedge clk); check("R8", periphAck, 0); step();
    bValid = 0;
  endtask

  task automatic testProto();
    doReset();
    pushReq(1'b1);
    ackLoadEn = 1; rValid = 1; rLast = 1;
    step();
    ackLoadEn = 0; rValid = 0; rLast = 0;
    pushReq(1'b0);
    @(negedge clk);
    check("R9", protoError, 0);
    step();
    pushReq(1'b1);
    pushReq(1'b0);
    @(negedge clk);
    check("R9", protoError, 1);
    step(); step();
    @(negedge clk);
    check("R9", protoError, 1);
    step();
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testWaitAnySingle();
    testWaitAnyBurst();
    testOrder();
    testWaitBurst();
    testFlush();
    testOverflow();
    testAck();
    testProto();
    testReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule